// File: doc/BRIEF.md
# Trigger Interval Capture Counter

This block measures the spacing between external trigger events. While measurement is enabled, a saturating interval counter advances by one on every cycle in which the count tick input is high. Whenever either of two trigger inputs is high in an enabled cycle, three things happen at once: the count held before that edge is latched into the capture register, the counter restarts from zero, and a one-cycle transmit shift event is pulsed. A one-cycle valid strobe marks each new captured value.

The tick comes from a rate chain elsewhere, and the triggers arrive already synchronized to the system clock. The captured value stays readable until the next capture or a reset. When measurement is disabled, the counter is held at zero and the triggers are ignored.

Top module: `trig_interval_capture`

## Requirements
- R1: While `meas_en` is 1 and no trigger is high, each cycle with `tick` high adds exactly one to the interval count, and a cycle with `tick` low leaves it unchanged.
- R2: The interval count stops at its maximum value of 1023 (all ones in 10 bits) and never wraps to zero on further ticks.
- R3: A rising clock edge that samples `meas_en` = 1 and either trigger bit high (`trig[0]` or `trig[1]`) copies the count held before that edge into `cap_value`, visible one cycle later, and restarts the count from zero.
- R4: Each capture is accompanied by `shift_evt` high for exactly one cycle, in the same cycle as the capture strobe.
- R5: While `meas_en` is 0, triggers cause no capture, no `cap_valid` and no `shift_evt`, and `cap_value` does not change.
- R6: When a trigger and a tick are sampled at the same edge, the count before the increment is captured and the counter ends at zero.
- R7: When both trigger bits are high at the same edge, exactly one capture, one `cap_valid` cycle and one `shift_evt` cycle result.
- R8: Clearing `meas_en` returns the interval count to zero, and the value already in `cap_value` is kept.
- R9: `cap_valid` is high for one cycle per capture and low in every cycle without a capture.
- R10: Synchronous reset sets `cap_value` to 0, `cap_valid` and `shift_evt` to 0, and the interval count to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| meas_en | input | 1 | Measurement enable; 0 holds the counter at zero and masks the triggers |
| tick | input | 1 | Count tick, one cycle wide per count step |
| trig | input | 2 | Synchronized trigger pulses; bit 0 is trigger A, bit 1 is trigger B |
| cap_value | output | 10 | Last captured interval count |
| cap_valid | output | 1 | One-cycle strobe marking a new value in `cap_value` |
| shift_evt | output | 1 | One-cycle transmit shift event pulse |

## Verification
Every result of this block is due one cycle after the edge that samples its cause: a trigger sampled at edge N shows up on `cap_value`, `cap_valid` and `shift_evt` right after edge N, and a tick sampled at edge N shows up in the count that the next trigger captures. The bench drives each stimulus at a falling edge, lets exactly one rising edge pass, and reads the outputs at the following falling edge, so every check lands in the cycle the result is due and the next stimulus has not yet been sampled. Checks that something stays absent, such as the strobe after a capture or a trigger while disabled, read the outputs one cycle later by the same rule.

// File: rtl/tic_pkg.sv
package tic_pkg;

  // Default width of the interval counter and the capture register.
  localparam int unsigned TIC_CNT_W = 10;

  // Default number of trigger inputs merged into one capture event.
  localparam int unsigned TIC_NUM_TRIG = 2;

  // Next value of a saturating counter step.
  function automatic logic [TIC_CNT_W-1:0] sat_step(input logic [TIC_CNT_W-1:0] cur);
    logic [TIC_CNT_W-1:0] top_val;
    top_val = '1;
    return (cur == top_val) ? cur : cur + 1'b1;
  endfunction

endpackage

// File: rtl/tic_trig_merge.sv
module tic_trig_merge #(
  parameter int unsigned NUM_TRIG = 2
) (
  input  logic                enable,
  input  logic [NUM_TRIG-1:0] trig,
  output logic                fire
);

  logic [NUM_TRIG:0] chain;

  assign chain[0] = 1'b0;

  // Any number of simultaneous triggers collapses to one event.
  for (genvar g = 0; g < NUM_TRIG; g++) begin : g_or
    assign chain[g+1] = chain[g] | trig[g];
  end

  assign fire = enable & chain[NUM_TRIG];

endmodule

// File: rtl/tic_sat_counter.sv
module tic_sat_counter #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             tick,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      count <= '0;
    end else if (clr) begin
      count <= '0;
    end else if (tick && (count != CNT_MAX)) begin
      count <= count + 1'b1;
    end
  end

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && !clr && tick && count != CNT_MAX) |=> (count == $past(count) + 1'b1));

  // R1
  cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && !clr && !tick) |=> $stable(count));

  // R2
  cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && !clr && count == CNT_MAX) |=> (count == CNT_MAX));

  // R3
  cnt_clr_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == '0));

  // R8
  cnt_off_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (count == '0));

endmodule

// File: rtl/tic_capture_reg.sv
module tic_capture_reg #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] din,
  output logic [CNT_W-1:0] value,
  output logic             valid,
  output logic             evt
);

  always_ff @(posedge clk) begin
    if (rst) begin
      value <= '0;
      valid <= 1'b0;
      evt   <= 1'b0;
    end else begin
      valid <= load;
      evt   <= load;
      if (load) begin
        value <= din;
      end
    end
  end

  // R3
  cap_load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (value == $past(din)));

  // R4
  cap_evt_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (evt && valid));

  // R9
  cap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> (!valid && !evt && $stable(value)));

endmodule

// File: rtl/trig_interval_capture.sv
module trig_interval_capture #(
  parameter int unsigned CNT_W    = tic_pkg::TIC_CNT_W,
  parameter int unsigned NUM_TRIG = tic_pkg::TIC_NUM_TRIG
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                meas_en,
  input  logic                tick,
  input  logic [NUM_TRIG-1:0] trig,
  output logic [CNT_W-1:0]    cap_value,
  output logic                cap_valid,
  output logic                shift_evt
);

  logic             fire;
  logic [CNT_W-1:0] interval_cnt;

  tic_trig_merge #(
    .NUM_TRIG (NUM_TRIG)
  ) u_merge (
    .enable (meas_en),
    .trig   (trig),
    .fire   (fire)
  );

  tic_sat_counter #(
    .CNT_W (CNT_W)
  ) u_counter (
    .clk    (clk),
    .rst    (rst),
    .enable (meas_en),
    .tick   (tick),
    .clr    (fire),
    .count  (interval_cnt)
  );

  tic_capture_reg #(
    .CNT_W (CNT_W)
  ) u_capture (
    .clk   (clk),
    .rst   (rst),
    .load  (fire),
    .din   (interval_cnt),
    .value (cap_value),
    .valid (cap_valid),
    .evt   (shift_evt)
  );

  // R5
  off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !meas_en |=> (!cap_valid && !shift_evt && $stable(cap_value)));

  // R4
  evt_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_valid == shift_evt));

  // R6
  tick_trig_chk: assert property (@(posedge clk) disable iff (rst)
    (meas_en && tick && (|trig)) |=> (interval_cnt == '0 && cap_value == $past(interval_cnt)));

  // R10
  rst_out_chk: assert property (@(posedge clk)
    rst |=> (cap_value == '0 && !cap_valid && !shift_evt));

endmodule

// File: tb/trig_interval_capture_bench.sv
module trig_interval_capture_bench;

  localparam int CW  = 10;
  localparam int MAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst;
  logic          meas_en;
  logic          tick;
  logic [1:0]    trig;
  logic [CW-1:0] cap_value;
  logic          cap_valid;
  logic          shift_evt;

  int n_chk  = 0;
  int n_fail = 0;
  int exp_cnt = 0;
  int exp_cap = 0;

  always #4 clk = ~clk;

  trig_interval_capture #(.CNT_W(CW), .NUM_TRIG(2)) u_trig_interval_capture (
    .clk       (clk),
    .rst       (rst),
    .meas_en   (meas_en),
    .tick      (tick),
    .trig      (trig),
    .cap_value (cap_value),
    .cap_valid (cap_valid),
    .shift_evt (shift_evt)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One clock: drive at the falling edge, one rising edge, read at the next falling edge.
  task automatic cyc(input logic tk, input logic [1:0] tg);
    tick = tk;
    trig = tg;
    if (!meas_en) exp_cnt = 0;
    else if (tg != 2'b00) begin exp_cap = exp_cnt; exp_cnt = 0; end
    else if (tk && exp_cnt < MAX) exp_cnt++;
    @(posedge clk);
    @(negedge clk);
    tick = 1'b0;
    trig = 2'b00;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 2'b00);
  endtask

  task automatic expect_capture(input string req);
    check({req, " cap_value"}, cap_value, exp_cap);
    check({req, " cap_valid"}, cap_valid, 1);
    check({req, " shift_evt"}, shift_evt, 1);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    meas_en = 1'b0;
    tick = 1'b0;
    trig = 2'b00;
    exp_cnt = 0;
    exp_cap = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R10 cap_value", cap_value, 0);
    check("R10 cap_valid", cap_valid, 0);
    check("R10 shift_evt", shift_evt, 0);
  endtask

  task automatic t_basic_a();
    meas_en = 1'b1;
    cyc(1'b0, 2'b00);
    ticks(5);
    cyc(1'b0, 2'b01);
    expect_capture("R3 trigA");
    check("R3 cap 5", cap_value, 5);
    cyc(1'b0, 2'b00);
    check("R9 strobe drops", cap_valid, 0);
    check("R4 event one cycle", shift_evt, 0);
  endtask

  task automatic t_gaps_b();
    cyc(1'b1, 2'b00);
    cyc(1'b0, 2'b00);
    cyc(1'b0, 2'b00);
    cyc(1'b1, 2'b00);
    cyc(1'b0, 2'b00);
    cyc(1'b1, 2'b00);
    cyc(1'b0, 2'b10);
    expect_capture("R1 trigB gaps");
    check("R1 cap 3", cap_value, 3);
  endtask

  task automatic t_tick_trig();
    ticks(4);
    cyc(1'b1, 2'b01);
    expect_capture("R6 tick+trig");
    check("R6 cap 4", cap_value, 4);
    cyc(1'b0, 2'b10);
    expect_capture("R6 counter cleared");
    check("R6 cap 0", cap_value, 0);
  endtask

  task automatic t_both();
    ticks(6);
    cyc(1'b0, 2'b11);
    expect_capture("R7 both");
    check("R7 cap 6", cap_value, 6);
    cyc(1'b0, 2'b00);
    check("R7 single strobe", cap_valid, 0);
    check("R7 single event", shift_evt, 0);
  endtask

  task automatic t_saturate();
    ticks(MAX + 7);
    cyc(1'b0, 2'b01);
    expect_capture("R2 saturate");
    check("R2 cap 1023", cap_value, MAX);
  endtask

  task automatic t_disabled();
    int held;
    ticks(9);
    cyc(1'b0, 2'b01);
    held = cap_value;
    check("R3 cap 9", held, 9);
    ticks(7);
    meas_en = 1'b0;
    cyc(1'b1, 2'b01);
    check("R5 no strobe", cap_valid, 0);
    check("R5 no event", shift_evt, 0);
    check("R5 value held", cap_value, held);
    cyc(1'b0, 2'b11);
    check("R5 no strobe both", cap_valid, 0);
    check("R8 value kept", cap_value, held);
    meas_en = 1'b1;
    ticks(2);
    cyc(1'b0, 2'b10);
    expect_capture("R8 count cleared by disable");
    check("R8 cap 2", cap_value, 2);
  endtask

  task automatic t_reset_mid();
    ticks(3);
    cyc(1'b0, 2'b01);
    check("R3 cap 3 pre-reset", cap_value, 3);
    ticks(5);
    do_reset();
    check("R10 value cleared", cap_value, 0);
    meas_en = 1'b1;
    cyc(1'b0, 2'b01);
    expect_capture("R10 count cleared");
    check("R10 cap 0", cap_value, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog cycles actual=200000 expected=fewer");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_basic_a();
    t_gaps_b();
    t_tick_trig();
    t_both();
    t_saturate();
    t_disabled();
    t_reset_mid();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule